// File: doc/BRIEF.md
# Keyed Group-Average Payload Decoder

This block recovers a hidden payload from the per-bit program times of one flash page. A measurement engine outside the block writes each cell's program time, an unsigned count of partial-program steps, into an internal page-sized store through a simple write port. On a start pulse the block walks a key-seeded permutation of the page's bit positions and cuts that walk into consecutive groups of `GS` members. It adds up the program times of each group's members and decides that group's payload bit by comparing the group average with a threshold `th`.

A group whose average program time is below the threshold was stressed more heavily when the payload was imprinted, so it decodes as 1; any other group decodes as 0. The threshold is a fixed-point input with four fractional bits. It is normally set midway between the averages seen for stressed and unstressed groups. The decision is made as `16*sum < th*GS`, which needs no divider. Payload bits leave in group index order, one beat per group, on a valid/ready stream. The last group's beat is flagged. The permutation generator has to be the same one that was used while imprinting, or group membership will not match.

Top module: `stego_group_decoder`

## Requirements
- R1: After a synchronous active-high reset, `busy` and `pay_valid` are 0.
- R2: Member k (0-based) of group g is the page bit at address s(g*GS+k)-1. Here s(0) is the seed and s(t+1) = {s(t)[AW-2:0], fb}, where fb is the XOR of the tap bits of s(t). With AW=6 the taps are bits 5 and 4.
- R3: `pay_bit` is 1 exactly when 16*sum < th*GS. Here sum is the total of the group's program times and `th` has 4 fractional bits. An average equal to the threshold decodes as 0.
- R4: Each start produces exactly NG beats, for groups 0..NG-1 in order. `pay_last` is 1 on the final beat only, and no further beat follows it.
- R5: While `pay_valid` is high and `pay_ready` is low, `pay_valid`, `pay_bit` and `pay_last` hold their values into the next cycle.
- R6: `busy` is 1 from the cycle after an accepted start until the final beat is accepted. `pay_valid` is never 1 while `busy` is 0. A start pulse while busy is ignored, and so are `key` changes made while busy.
- R7: A key of 0 is replaced by a seed of 1; any nonzero key is used as the seed.
- R8: A write with `wr_en` high stores `wr_time` as the program time of page bit `wr_addr`. Later decodes use the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Program-time write strobe |
| wr_addr | input | AW | Page bit address written |
| wr_time | input | TW | Program time of that bit |
| key | input | AW | Hiding key, sampled at start |
| th | input | TW+4 | Threshold, 4 fractional bits |
| start | input | 1 | Begin decoding the page |
| busy | output | 1 | Decode in progress |
| pay_valid | output | 1 | Payload beat available |
| pay_ready | input | 1 | Consumer accepts beat |
| pay_bit | output | 1 | Decoded payload bit |
| pay_last | output | 1 | Beat belongs to the final group |

## Verification
An error in the permutation walk or in the group counter changes the membership of every group from that point onward. It therefore shows up as wrong `pay_bit` values within the first few beats of any key. It also shows up as a misplaced `pay_last` or as a missing or extra beat, visible when the run ends. An accumulator that fails to clear between groups biases each later sum and flips bits near the threshold. Exact-threshold pages expose an off-by-one in the comparison on the very first beat. Stalling the consumer exposes output registers that move while held.

// File: rtl/stego_pkg.sv
package stego_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } dec_state_t;

  // Maximal-length feedback tap masks, bit n-1 set for tap n
  function automatic logic [31:0] lfsr_taps(input int width);
    logic [31:0] m;
    case (width)
      3:       m = 32'h0000_0006;
      4:       m = 32'h0000_000C;
      5:       m = 32'h0000_0014;
      6:       m = 32'h0000_0030;
      7:       m = 32'h0000_0060;
      8:       m = 32'h0000_00B8;
      9:       m = 32'h0000_0110;
      10:      m = 32'h0000_0240;
      11:      m = 32'h0000_0500;
      12:      m = 32'h0000_0829;
      13:      m = 32'h0000_100D;
      14:      m = 32'h0000_2015;
      15:      m = 32'h0000_6000;
      default: m = 32'h0000_D008;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/stego_walk.sv
module stego_walk #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] seed,
  input  logic          step,
  output logic [AW-1:0] state
);
  localparam logic [AW-1:0] TAPS = AW'(stego_pkg::lfsr_taps(AW));

  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= AW'(1);
    end else if (load) begin
      state <= seed;
    end else if (step) begin
      state <= {state[AW-2:0], fb};
    end
  end

  // R2
  walk_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);

endmodule

// File: rtl/stego_time_ram.sv
module stego_time_ram #(
  parameter int AW = 11,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [TW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [TW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [TW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/stego_group_judge.sv
module stego_group_judge #(
  parameter int TW = 8,
  parameter int GS = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          in_glast,
  input  logic [TW-1:0] in_time,
  input  logic [TW+3:0] th,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_bit,
  output logic          out_last
);
  localparam int SW = TW + $clog2(GS + 1);
  localparam int PW = SW + 4;

  logic [SW-1:0] acc;
  logic [SW-1:0] total;
  logic [PW-1:0] lhs;
  logic [PW-1:0] rhs;

  always_comb begin
    total = (in_first ? '0 : acc) + SW'(in_time);
    lhs   = {total, 4'b0000};
    rhs   = PW'(th) * PW'(GS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (in_v) begin
        acc <= total;
        if (in_last) begin
          out_valid <= 1'b1;
          out_bit   <= (lhs < rhs);
          out_last  <= in_glast;
        end
      end
    end
  end

  // R5
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last));

  // R3
  result_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_v && in_last));

endmodule

// File: rtl/stego_group_decoder.sv
module stego_group_decoder #(
  parameter int AW = 11,
  parameter int TW = 8,
  parameter int GS = 128,
  parameter int NG = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_time,
  input  logic [AW-1:0] key,
  input  logic [TW+3:0] th,
  input  logic          start,
  output logic          busy,
  output logic          pay_valid,
  input  logic          pay_ready,
  output logic          pay_bit,
  output logic          pay_last
);
  import stego_pkg::*;

  localparam int GW = $clog2(GS);
  localparam int NGW = (NG > 1) ? $clog2(NG) : 1;
  localparam logic [GW-1:0] K_END = GW'(GS - 1);
  localparam logic [NGW-1:0] G_END = NGW'(NG - 1);

  dec_state_t     st;
  logic [GW-1:0]  mem_k;
  logic [NGW-1:0] grp;
  logic           rd_v, rd_first, rd_last, rd_glast;

  logic           walk_load, walk_step;
  logic [AW-1:0]  walk_seed, walk_state, raddr;
  logic [TW-1:0]  rd_time;

  assign walk_load = (st == ST_IDLE) && start;
  assign walk_step = (st == ST_ISSUE);
  assign walk_seed = (key == '0) ? AW'(1) : key;
  assign raddr     = walk_state - AW'(1);
  assign busy      = (st != ST_IDLE);

  stego_walk #(.AW(AW)) u_walk (
    .clk   (clk),
    .rst   (rst),
    .load  (walk_load),
    .seed  (walk_seed),
    .step  (walk_step),
    .state (walk_state)
  );

  stego_time_ram #(.AW(AW), .TW(TW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_time),
    .raddr (raddr),
    .rdata (rd_time)
  );

  stego_group_judge #(.TW(TW), .GS(GS)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .in_v      (rd_v),
    .in_first  (rd_first),
    .in_last   (rd_last),
    .in_glast  (rd_glast),
    .in_time   (rd_time),
    .th        (th),
    .out_ready (pay_ready),
    .out_valid (pay_valid),
    .out_bit   (pay_bit),
    .out_last  (pay_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_k    <= '0;
      grp      <= '0;
      rd_v     <= 1'b0;
      rd_first <= 1'b0;
      rd_last  <= 1'b0;
      rd_glast <= 1'b0;
    end else begin
      rd_v <= (st == ST_ISSUE);
      case (st)
        ST_IDLE: begin
          if (start) begin
            mem_k <= '0;
            grp   <= '0;
            st    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          rd_first <= (mem_k == '0);
          rd_last  <= (mem_k == K_END);
          rd_glast <= (grp == G_END);
          if (mem_k == K_END) begin
            mem_k <= '0;
            st    <= ST_WAIT;
          end else begin
            mem_k <= mem_k + GW'(1);
          end
        end
        ST_WAIT: begin
          if (pay_valid && pay_ready) begin
            if (grp == G_END) begin
              st <= ST_IDLE;
            end else begin
              grp <= grp + NGW'(1);
              st  <= ST_ISSUE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  final_beat_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
    pay_valid && pay_ready && pay_last |=> !busy);

  // R6
  no_beat_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pay_valid);

  // R4
  last_only_at_final_chk: assert property (@(posedge clk) disable iff (rst)
    pay_valid && pay_last |-> grp == G_END);

endmodule

// File: tb/stego_group_decoder_bench.sv
module stego_group_decoder_bench;
  localparam int AW = 6;
  localparam int TW = 4;
  localparam int GS = 4;
  localparam int NG = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [TW-1:0] wr_time = '0;
  logic [AW-1:0] key = '0;
  logic [TW+3:0] th = '0;
  logic          start = 1'b0;
  logic          busy, pay_valid, pay_bit, pay_last;
  logic          pay_ready = 1'b0;

  int total = 0;
  int bad = 0;
  int model_t [64];
  bit exp_bits [NG];

  always #2 clk = ~clk;

  stego_group_decoder #(.AW(AW), .TW(TW), .GS(GS), .NG(NG)) u_stego_group_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_time(wr_time),
    .key(key), .th(th), .start(start), .busy(busy), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .pay_bit(pay_bit), .pay_last(pay_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R8: fill the page through the write port
  task automatic load_page(input int mode);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = AW'(i);
      model_t[i] = (mode == 0) ? ((i * 7 + 3) % 16) : (mode == 1) ? 5 : ((i * i + i / 3) % 16);
      wr_time = TW'(model_t[i]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R2, R3, R7: arithmetic model of the walk and the decision
  task automatic calc_exp(input int k, input int thv);
    int s;
    int sum;
    s = (k == 0) ? 1 : k;
    for (int g = 0; g < NG; g++) begin
      sum = 0;
      for (int m = 0; m < GS; m++) begin
        sum += model_t[s - 1];
        s = ((s << 1) & 63) | (((s >> 5) ^ (s >> 4)) & 1);
      end
      exp_bits[g] = (sum * 16 < thv * GS);
    end
  endtask

  task automatic run_case(input int k, input int thv, input int rmode, input bit restart);
    int beats = 0;
    int cyc = 0;
    bit stall = 1'b0;
    bit pb = 1'b0;
    bit pl = 1'b0;
    calc_exp(k, thv);
    @(negedge clk);
    key = AW'(k);
    th = 8'(thv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
    while (beats < NG && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = restart && (cyc == 5);
      if (restart && cyc == 5) key = AW'(k ^ 6'h2A);
      case (rmode)
        0: pay_ready = 1'b1;
        1: pay_ready = (cyc % 3) != 0;
        default: pay_ready = (cyc % 4) < 2;
      endcase
      #1;
      if (stall) begin
        chk(pay_valid == 1'b1, "R5 valid held", int'(pay_valid), 1);
        chk(pay_bit == pb && pay_last == pl, "R5 bit/last held",
            int'({pay_bit, pay_last}), int'({pb, pl}));
      end
      if (pay_valid && pay_ready) begin
        chk(pay_bit == exp_bits[beats], "R3 R2 payload bit", int'(pay_bit), int'(exp_bits[beats]));
        chk(pay_last == (beats == NG - 1), "R4 last flag", int'(pay_last), int'(beats == NG - 1));
        beats++;
      end
      stall = pay_valid && !pay_ready;
      pb = pay_bit;
      pl = pay_last;
    end
    chk(beats == NG, "R4 beat count", beats, NG);
    @(negedge clk);
    start = 1'b0;
    pay_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b0, "R6 idle after final beat", int'(busy), 0);
    chk(pay_valid == 1'b0, "R4 no extra beat", int'(pay_valid), 0);
    pay_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    chk(pay_valid == 1'b0, "R1 valid at reset", int'(pay_valid), 0);

    // R3 exact-threshold boundaries on a flat page
    load_page(1);
    run_case(9, 80, 0, 1'b0);
    run_case(9, 81, 0, 1'b0);
    run_case(9, 79, 1, 1'b0);

    // R2 R7 sweeps over keys and thresholds
    load_page(0);
    for (int ki = 0; ki < 6; ki++) begin
      for (int ti = 0; ti < 4; ti++) begin
        int kv;
        int tv;
        kv = (ki == 0) ? 0 : (ki == 1) ? 1 : (ki == 2) ? 2 : (ki == 3) ? 37 : (ki == 4) ? 63 : 20;
        tv = (ti == 0) ? 0 : (ti == 1) ? 120 : (ti == 2) ? 136 : 255;
        run_case(kv, tv, (ki + ti) % 3, 1'b0);
      end
    end

    // R6 start and key changes while busy are ignored
    run_case(37, 128, 1, 1'b1);

    // R8 a rewritten page changes the decode
    load_page(2);
    run_case(0, 120, 2, 1'b0);
    run_case(44, 128, 0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule